// File: doc/BRIEF.md
# PWM Global Channel Control and Interrupt Combiner

This block holds the controller-wide registers of a multi-channel pulse-width modulator. Software starts and stops channels through two separate write-only words. One word turns on every channel whose bit is 1, and the other turns those channels off. Because of this, no read-modify-write is ever needed. The per-channel interrupt mask is handled the same way, through an unmask word and a mask word, and a read-only view of the mask is provided. A status view shows which channels are currently running.

Each channel reports the end of every period as a one-cycle event. The block latches these events into a pending word, with bit n belonging to channel n, so that a handler that scans from bit 0 upward serves channels in index order. Reading the pending word returns its contents and clears it in the same access. An event that arrives in the same cycle as that read survives the read. A single interrupt line is raised whenever an unmasked bit is pending. A plain read/write mode word at offset 0x00 is kept for the clock-divider logic, which lives outside this block.

Top module: `pwm_glb_ctl`

## Requirements
- R1: After reset, channel enables, interrupt mask, pending bits, mode word and `irq` are all 0.
- R2: A write to offset 0x04 sets channel enable n for every bit n of the write data that is 1. Zero bits leave their enables unchanged.
- R3: A write to offset 0x08 clears channel enable n for every bit n of the write data that is 1. Zero bits leave their enables unchanged.
- R4: A read of offset 0x0C returns the channel enables in bits [NCH-1:0], which equal `ch_en`, and 0 in all higher bits.
- R5: A write to offset 0x10 unmasks channel n for each 1 bit, and a write to offset 0x14 masks channel n for each 1 bit. Offset 0x18 reads back the mask, with 1 meaning unmasked.
- R6: A high `ch_evt[n]` at a clock edge sets pending bit n, and the bit stays set until offset 0x1C is read.
- R7: A read of offset 0x1C returns the pending bits at bit positions equal to the channel index and clears them at the clock edge that ends the read.
- R8: An event that arrives at the same edge as a read of offset 0x1C is not included in that read's data and stays pending afterwards.
- R9: `irq` is 1 exactly when some bit is both pending and unmasked.
- R10: Offset 0x00 is a full-width read/write word whose stored value drives `mode_word`.
- R11: Offsets 0x04, 0x08, 0x10, 0x14 and unmapped offsets read 0. Writes to 0x0C, 0x18, 0x1C or unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_rd | input | 1 | Read strobe; side effects happen at the rising edge |
| bus_addr | input | 8 | Byte offset of the global register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from `bus_addr` |
| ch_evt | input | NCH | One-cycle end-of-period events, one per channel |
| ch_en | output | NCH | Channel enables |
| mode_word | output | DW | Stored mode word for the clock dividers |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data is combinational, so a read is sampled shortly after the falling edge at which its address was driven, before the edge that carries out any clear. Writes and events take effect at the next rising edge. The bench therefore checks `ch_en`, `irq` and any read-back at the falling edge that follows that rising edge, which is one cycle after the stimulus. The pending clear shows up on the next read after the acknowledging one. For the same-edge case the bench drives the event together with the read and expects the old data now and the new event on the following read.

// File: rtl/pwm_glb_pkg.sv
package pwm_glb_pkg;
  localparam int ADDR_W = 8;
  localparam int MAX_CH = 32;

  localparam logic [ADDR_W-1:0] OFF_MODE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_RUN   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STOP  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_UNMSK = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_MSK   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MVIEW = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_PEND  = 8'h1C;

  // set/clear update; the two strobes never arrive together, clear wins if they do
  function automatic logic [MAX_CH-1:0] w1sc_next(input logic [MAX_CH-1:0] q,
                                                  input logic [MAX_CH-1:0] set,
                                                  input logic [MAX_CH-1:0] clr);
    return (q | set) & ~clr;
  endfunction

  // pending update: an acknowledge wipes old bits, new events always land
  function automatic logic [MAX_CH-1:0] pend_next(input logic [MAX_CH-1:0] q,
                                                  input logic [MAX_CH-1:0] evt,
                                                  input logic ack);
    return (ack ? '0 : q) | evt;
  endfunction
endpackage

// File: rtl/pwm_w1sc_bank.sv
module pwm_w1sc_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  import pwm_glb_pkg::*;

  logic [N-1:0] q_d;

  always_comb begin
    q_d = N'(w1sc_next(MAX_CH'(q_o), MAX_CH'(set_i), MAX_CH'(clr_i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  // also covers R5 when the bank holds the interrupt mask
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0 && clr_i == '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_clr_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/pwm_evt_pend.sv
module pwm_evt_pend #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         ack_i,
  output logic [N-1:0] pend_o
);
  import pwm_glb_pkg::*;

  logic [N-1:0] pend_d;

  always_comb begin
    pend_d = N'(pend_next(MAX_CH'(pend_o), MAX_CH'(evt_i), ack_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= pend_d;
  end

  p_evt_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && evt_i == '0) |=> (pend_o == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/pwm_glb_ctl.sv
module pwm_glb_ctl #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_wr,
  input  logic                            bus_rd,
  input  logic [pwm_glb_pkg::ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]                   bus_wdata,
  output logic [DW-1:0]                   bus_rdata,
  input  logic [NCH-1:0]                  ch_evt,
  output logic [NCH-1:0]                  ch_en,
  output logic [DW-1:0]                   mode_word,
  output logic                            irq
);
  import pwm_glb_pkg::*;

  // named decode events, visible to the assertions
  logic wr_mode, wr_run, wr_stop, wr_unmsk, wr_msk, rd_pend_ack;
  logic [NCH-1:0] run_set, run_clr, msk_set, msk_clr;
  logic [NCH-1:0] unmasked, pend;
  logic [NCH-1:0] live_irq;
  logic [DW-1:0]  mode_q;

  assign wr_mode     = bus_wr && (bus_addr == OFF_MODE);
  assign wr_run      = bus_wr && (bus_addr == OFF_RUN);
  assign wr_stop     = bus_wr && (bus_addr == OFF_STOP);
  assign wr_unmsk    = bus_wr && (bus_addr == OFF_UNMSK);
  assign wr_msk      = bus_wr && (bus_addr == OFF_MSK);
  assign rd_pend_ack = bus_rd && (bus_addr == OFF_PEND);

  assign run_set = wr_run   ? bus_wdata[NCH-1:0] : '0;
  assign run_clr = wr_stop  ? bus_wdata[NCH-1:0] : '0;
  assign msk_set = wr_unmsk ? bus_wdata[NCH-1:0] : '0;
  assign msk_clr = wr_msk   ? bus_wdata[NCH-1:0] : '0;

  pwm_w1sc_bank #(.N(NCH)) u_run (
    .clk(clk), .rst_n(rst_n), .set_i(run_set), .clr_i(run_clr), .q_o(ch_en)
  );

  pwm_w1sc_bank #(.N(NCH)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_i(msk_set), .clr_i(msk_clr), .q_o(unmasked)
  );

  pwm_evt_pend #(.N(NCH)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_i(ch_evt), .ack_i(rd_pend_ack), .pend_o(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (wr_mode) mode_q <= bus_wdata;
  end
  assign mode_word = mode_q;

  assign live_irq = pend & unmasked;
  assign irq      = |live_irq;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_MODE:  bus_rdata = mode_q;
      OFF_STAT:  bus_rdata[NCH-1:0] = ch_en;
      OFF_MVIEW: bus_rdata[NCH-1:0] = unmasked;
      OFF_PEND:  bus_rdata[NCH-1:0] = pend;
      default:   bus_rdata = '0;
    endcase
  end

  p_stat_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_STAT) |-> (bus_rdata == DW'(ch_en)));

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (unmasked != '0 && pend != '0));

  p_mode_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_word == $past(bus_wdata)));

  p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_STAT) |=> $stable(ch_en));
endmodule

// File: tb/pwm_glb_ctl_tb.sv
module pwm_glb_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [NCH-1:0] ch_evt = '0;
  logic [NCH-1:0] ch_en;
  logic [DW-1:0] mode_word;
  logic irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_glb_ctl #(.NCH(NCH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_evt(ch_evt), .ch_en(ch_en), .mode_word(mode_word), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // combinational data sampled before the edge that performs side effects
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] e);
    @(negedge clk);
    ch_evt = e;
    @(negedge clk);
    ch_evt = '0;
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NCH-1:0] en_m, msk_m, pnd_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(ch_en == '0, "R1 ch_en", 32'(ch_en), 0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(mode_word == '0, "R1 mode_word", mode_word, 0);
    rd(8'h0C, d); chk(d == 0, "R1 status", d, 0);
    rd(8'h18, d); chk(d == 0, "R1 mask", d, 0);
    rd(8'h1C, d); chk(d == 0, "R1 pending", d, 0);

    // R2 R3 R4: every start state against every write pattern
    for (int s = 0; s < 16; s++) begin
      for (int p = 0; p < 16; p++) begin
        wr(8'h08, 32'hF);
        wr(8'h04, 32'(s));
        en_m = NCH'(s);
        wr(8'h04, 32'(p));
        en_m = en_m | NCH'(p);
        chk(ch_en == en_m, "R2 set", 32'(ch_en), 32'(en_m));
        rd(8'h0C, d);
        chk(d == 32'(en_m), "R4 status", d, 32'(en_m));
        wr(8'h08, 32'(p));
        en_m = en_m & ~NCH'(p);
        chk(ch_en == en_m, "R3 clear", 32'(ch_en), 32'(en_m));
      end
    end
    wr(8'h08, 32'hF);
    wr(8'h04, 32'hFFFF_FFF5);
    rd(8'h0C, d);
    chk(d == 32'h5, "R4 upper bits zero", d, 32'h5);
    wr(8'h08, 32'hF);

    // R5 R6 R7 R9: every mask against every event pattern
    for (int m = 0; m < 16; m++) begin
      wr(8'h14, 32'hF);
      wr(8'h10, 32'(m));
      msk_m = NCH'(m);
      rd(8'h18, d);
      chk(d == 32'(msk_m), "R5 mask view", d, 32'(msk_m));
      for (int p = 0; p < 16; p++) begin
        pulse(NCH'(p));
        pnd_m = NCH'(p);
        chk(irq == (|(pnd_m & msk_m)), "R9 irq", 32'(irq), 32'(|(pnd_m & msk_m)));
        pulse('0);
        chk(irq == (|(pnd_m & msk_m)), "R6 pending held", 32'(irq), 32'(|(pnd_m & msk_m)));
        rd(8'h1C, d);
        chk(d == 32'(pnd_m), "R7 pending read", d, 32'(pnd_m));
        #1;
        chk(irq == 1'b0, "R7 irq after ack", 32'(irq), 0);
      end
      wr(8'h14, 32'(m));
      rd(8'h18, d);
      chk(d == 0, "R5 masked again", d, 0);
    end

    // R6 bit position follows channel index, accumulation across events
    pulse(4'b0100);
    pulse(4'b0001);
    rd(8'h1C, d);
    chk(d == 32'h5, "R6 index order", d, 32'h5);

    // R8 event arriving on the acknowledging edge
    pulse(4'b0011);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 8'h1C; ch_evt = 4'b1100;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; ch_evt = '0;
    chk(d == 32'h3, "R8 read excludes new event", d, 32'h3);
    rd(8'h1C, d);
    chk(d == 32'hC, "R8 new event kept", d, 32'hC);
    rd(8'h1C, d);
    chk(d == 0, "R7 cleared", d, 0);

    // R10 mode word
    wr(8'h00, 32'hA5C3_1E0F);
    rd(8'h00, d);
    chk(d == 32'hA5C3_1E0F, "R10 readback", d, 32'hA5C3_1E0F);
    chk(mode_word == 32'hA5C3_1E0F, "R10 output", mode_word, 32'hA5C3_1E0F);

    // R11 write-only reads zero, read-only and unmapped writes ignored
    wr(8'h04, 32'h6);
    wr(8'h10, 32'h9);
    pulse(4'b0010);
    wr(8'h0C, 32'hF);
    wr(8'h18, 32'hF);
    wr(8'h1C, 32'hF);
    wr(8'h20, 32'hF);
    chk(ch_en == 4'h6, "R11 status write ignored", 32'(ch_en), 32'h6);
    rd(8'h18, d); chk(d == 32'h9, "R11 mask view write ignored", d, 32'h9);
    chk(irq == 1'b0, "R11 irq unchanged", 32'(irq), 0);
    rd(8'h04, d); chk(d == 0, "R11 run reads zero", d, 0);
    rd(8'h14, d); chk(d == 0, "R11 mask word reads zero", d, 0);
    rd(8'h20, d); chk(d == 0, "R11 unmapped reads zero", d, 0);
    rd(8'h1C, d); chk(d == 32'h2, "R11 pending write ignored", d, 32'h2);
    chk(mode_word == 32'hA5C3_1E0F, "R11 mode unchanged", mode_word, 32'hA5C3_1E0F);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule